// File: doc/BRIEF.md
# Gate-Selected FSK Pulse Generator

A down-counter pulse-train generator whose output alternates between an inactive delay phase and an active pulse phase. Two independent count pairs are held on chip. When the synchronized gate input is low, the generator uses the low-gate pair; when it is high, it uses the high-gate pair. One counter therefore produces two distinct frequency/duty-cycle trains, and the gate level selects which one is active. This is frequency-shift keying.

All timing is measured in ticks of an external timebase enable. A phase of count N lasts exactly N ticks. The four counts are written through a small write port after reset and before the block is armed. Once armed, the generator runs until reset. Clearing arm does not stop it. A polarity input inverts the output. A one-clock terminal-count flag marks the end of each pulse phase.

Top module: `fsk_pulse_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `pulse_out` is 0 (with `invert` = 0) and `tc` is 0.
- R2: With the gate low, the output is inactive for count slot 0 ticks (the low-gate delay) and then active for count slot 1 ticks (the low-gate pulse). This repeats.
- R3: With the gate high, the same alternation uses count slot 2 as the delay and count slot 3 as the pulse.
- R4: The gate passes through a two-flop synchronizer. It is sampled only when a delay phase starts, which happens at arm or at the end of a pulse. The delay phase and the pulse that follows it keep the pair that was chosen at that moment.
- R5: A written count below 2 is stored as 2. A phase never lasts fewer than 2 ticks.
- R6: `tc` is high for exactly one clock, in the cycle after the tick that ends each pulse phase.
- R7: Once armed, the generator runs until reset. While it runs, count writes and further arm strobes are ignored. Reset returns it to idle.
- R8: `pulse_out` is a register that equals (pulse phase active) XOR `invert`. While idle it equals `invert`.
- R9: The down-counter changes only on `tick`. Each phase lasts exactly its count in ticks, whatever the spacing between ticks.
- R10: After reset the count slots hold the parameter defaults `DEF_LO_DLY`, `DEF_LO_PLS`, `DEF_HI_DLY` and `DEF_HI_PLS`. Slot encoding on `wr_sel` is: 0 = low-gate delay, 1 = low-gate pulse, 2 = high-gate delay, 3 = high-gate pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one clock wide |
| gate | input | 1 | Asynchronous gate level that selects the count pair |
| arm | input | 1 | Start strobe, effective only when idle |
| invert | input | 1 | Output polarity inversion |
| wr_en | input | 1 | Count write strobe, effective only when idle |
| wr_sel | input | 2 | Count slot index |
| wr_data | input | CNT_W | Count value |
| pulse_out | output | 1 | Registered pulse train |
| tc | output | 1 | One-clock flag at the end of each pulse phase |

## Verification
Assertions check several properties on every cycle. The counter holds still between ticks. It never sits at zero while running. Once running, it never returns to idle without reset. `tc` is a single clock wide and is always followed by a delay phase. The idle output follows `invert`. Phase lengths depend on the gate sampling point, the clamping of writes, the blocking of writes while running and the tick spacing. These can only be shown by the bench scenarios. The bench measures run lengths and compares them against a behavioural model every clock.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_PULSE = 2'd2
  } phase_t;

  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned MIN_COUNT = 2;
endpackage

// File: rtl/fsk_gate_sync.sv
module fsk_gate_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/fsk_count_bank.sv
module fsk_count_bank
  import fsk_pkg::*;
#(
  parameter int unsigned W      = 24,
  parameter int unsigned DEF_S0 = 5000000,
  parameter int unsigned DEF_S1 = 10000000,
  parameter int unsigned DEF_S2 = 4000000,
  parameter int unsigned DEF_S3 = 6000000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_ok,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] slot [NUM_SLOTS]
);
  localparam logic [W-1:0] MIN_W = W'(MIN_COUNT);
  localparam logic [W-1:0] DEFS [NUM_SLOTS] =
    '{W'(DEF_S0), W'(DEF_S1), W'(DEF_S2), W'(DEF_S3)};

  logic [W-1:0] wr_val;

  // clamp short counts so every phase spans at least MIN_COUNT ticks
  always_comb wr_val = (wr_data < MIN_W) ? MIN_W : wr_data;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                  slot[i] <= DEFS[i];
      else if (wr_ok && (wr_sel == 2'(i)))      slot[i] <= wr_val;
    end
  end
endmodule

// File: rtl/fsk_phase_ctrl.sv
module fsk_phase_ctrl
  import fsk_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         gate_s,
  input  logic         arm,
  input  logic [W-1:0] lo_dly,
  input  logic [W-1:0] lo_pls,
  input  logic [W-1:0] hi_dly,
  input  logic [W-1:0] hi_pls,
  output phase_t       phase,
  output logic [W-1:0] cnt,
  output logic         pulse_done
);
  logic         sel_hi;
  logic         last;
  logic [W-1:0] dly_next;
  logic [W-1:0] pls_len;

  always_comb begin
    last     = (cnt == W'(1));
    dly_next = gate_s ? hi_dly : lo_dly;
    pls_len  = sel_hi ? hi_pls : lo_pls;
  end

  assign pulse_done = (phase == PH_PULSE) && tick && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      sel_hi <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (arm) begin
            phase  <= PH_DELAY;
            sel_hi <= gate_s;
            cnt    <= dly_next;
          end
        end
        PH_DELAY: begin
          if (tick) begin
            if (last) begin
              phase <= PH_PULSE;
              cnt   <= pls_len;
            end else begin
              cnt <= cnt - W'(1);
            end
          end
        end
        PH_PULSE: begin
          if (tick) begin
            if (last) begin
              phase  <= PH_DELAY;
              sel_hi <= gate_s;
              cnt    <= dly_next;
            end else begin
              cnt <= cnt - W'(1);
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fsk_pulse_gen.sv
module fsk_pulse_gen
  import fsk_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEF_LO_DLY  = 5000000,
  parameter int unsigned DEF_LO_PLS  = 10000000,
  parameter int unsigned DEF_HI_DLY  = 4000000,
  parameter int unsigned DEF_HI_PLS  = 6000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate,
  input  logic             arm,
  input  logic             invert,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pulse_out,
  output logic             tc
);
  logic             gate_s;
  logic [CNT_W-1:0] slot_w [NUM_SLOTS];
  phase_t           phase_w;
  logic [CNT_W-1:0] cnt_w;
  logic             done_w;
  logic             wr_ok;

  assign wr_ok = wr_en && (phase_w == PH_IDLE);

  fsk_gate_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(gate), .q(gate_s)
  );

  fsk_count_bank #(
    .W(CNT_W), .DEF_S0(DEF_LO_DLY), .DEF_S1(DEF_LO_PLS),
    .DEF_S2(DEF_HI_DLY), .DEF_S3(DEF_HI_PLS)
  ) bank_i (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wr_sel(wr_sel),
    .wr_data(wr_data), .slot(slot_w)
  );

  fsk_phase_ctrl #(.W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .tick(tick), .gate_s(gate_s), .arm(arm),
    .lo_dly(slot_w[0]), .lo_pls(slot_w[1]),
    .hi_dly(slot_w[2]), .hi_pls(slot_w[3]),
    .phase(phase_w), .cnt(cnt_w), .pulse_done(done_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_out <= 1'b0;
      tc        <= 1'b0;
    end else begin
      pulse_out <= (phase_w == PH_PULSE) ^ invert;
      tc        <= done_w;
    end
  end
endmodule

// File: rtl/fsk_pulse_gen_chk.sv
module fsk_pulse_gen_chk #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         invert,
  input logic         pulse_out,
  input logic         tc,
  input logic [1:0]   phase,
  input logic [W-1:0] cnt
);
  localparam logic [1:0] IDLE  = 2'd0;
  localparam logic [1:0] DELAY = 2'd1;

  // R9: counter holds between ticks while running
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (phase != IDLE && !tick) |=> $stable(cnt));

  // R5: a running phase never sits at zero
  p_cnt_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    (phase != IDLE) |-> (cnt != '0));

  // R7: once running, never back to idle without reset
  p_run_persists_r7: assert property (@(posedge clk) disable iff (rst)
    (phase != IDLE) |=> (phase != IDLE));

  // R6: terminal flag is one clock wide
  p_tc_single_r6: assert property (@(posedge clk) disable iff (rst)
    tc |=> !tc);

  // R6: terminal flag always coincides with a fresh delay phase
  p_tc_phase_r6: assert property (@(posedge clk) disable iff (rst)
    tc |-> (phase == DELAY));

  // R8: settled idle output follows polarity
  p_idle_out_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == IDLE && $past(phase) == IDLE && $stable(invert) && !$past(rst))
      |-> (pulse_out == invert));
endmodule

bind fsk_pulse_gen fsk_pulse_gen_chk #(.W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .invert(invert),
  .pulse_out(pulse_out), .tc(tc), .phase(phase_w), .cnt(cnt_w)
);

// File: tb/fsk_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module fsk_pulse_gen_tb_top;
  localparam int W  = 24;
  localparam int D0 = 5, D1 = 7, D2 = 4, D3 = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1, gate = 1'b0, arm = 1'b0, invert = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic pulse_out, tc;

  int checks = 0, fails = 0;
  int tick_div = 1, tcount = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fsk_pulse_gen #(
    .CNT_W(W), .DEF_LO_DLY(D0), .DEF_LO_PLS(D1),
    .DEF_HI_DLY(D2), .DEF_HI_PLS(D3)
  ) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .arm(arm),
    .invert(invert), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pulse_out(pulse_out), .tc(tc)
  );

  always @(negedge clk) begin
    tcount++;
    tick = (tick_div <= 1) || (tcount % tick_div == 0);
  end

  // behavioural reference: elapsed-tick counting per phase
  int  m_regs [4];
  int  m_mode;          // 0 idle, 1 delay, 2 pulse
  int  m_len, m_el;
  bit  m_hi, m_g1, m_g2, m_out, m_tc;

  always @(posedge clk) begin
    if (rst) begin
      m_regs[0] <= D0; m_regs[1] <= D1; m_regs[2] <= D2; m_regs[3] <= D3;
      m_mode <= 0; m_len <= 0; m_el <= 0; m_hi <= 0;
      m_g1 <= 0; m_g2 <= 0; m_out <= 0; m_tc <= 0;
    end else begin
      m_out <= (m_mode == 2) ^ invert;
      m_tc  <= 0;
      m_g1  <= gate; m_g2 <= m_g1;
      if (wr_en && m_mode == 0)
        m_regs[wr_sel] <= (int'(wr_data) < 2) ? 2 : int'(wr_data);
      if (m_mode == 0) begin
        if (arm) begin
          m_mode <= 1; m_hi <= m_g2; m_el <= 0;
          m_len <= m_g2 ? m_regs[2] : m_regs[0];
        end
      end else if (tick) begin
        if (m_el + 1 < m_len) m_el <= m_el + 1;
        else if (m_mode == 1) begin
          m_mode <= 2; m_el <= 0;
          m_len <= m_hi ? m_regs[3] : m_regs[1];
        end else begin
          m_mode <= 1; m_el <= 0; m_tc <= 1; m_hi <= m_g2;
          m_len <= m_g2 ? m_regs[2] : m_regs[0];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) if (!done) begin
    check(pulse_out == m_out, "R9 pulse_out vs model", pulse_out, m_out);
    check(tc == m_tc, "R6 tc vs model", tc, m_tc);
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; arm = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wr(input int s, input int v);
    @(negedge clk); wr_en = 1; wr_sel = 2'(s); wr_data = W'(v);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  // length in clocks of the next complete run of pulse_out at level lvl
  task automatic run_len(input logic lvl, output int n);
    int g = 0;
    n = 0;
    while (pulse_out == lvl && g < 2000) begin @(negedge clk); g++; end
    while (pulse_out != lvl && g < 2000) begin @(negedge clk); g++; end
    while (pulse_out == lvl && g < 2000) begin n++; @(negedge clk); g++; end
  endtask

  initial begin
    int n;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(pulse_out == 0, "R1 pulse_out in reset", pulse_out, 0);
    check(tc == 0, "R1 tc in reset", tc, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    check(pulse_out == 0 && tc == 0, "R1 idle after reset", pulse_out, 0);

    // R10: defaults used without writes, gate low
    do_arm();
    run_len(1'b1, n); check(n == D1, "R10 default low-gate pulse", n, D1);
    run_len(1'b0, n); check(n == D0, "R10 default low-gate delay", n, D0);

    // R2 / R3: programmed pairs, gate low then high
    do_reset();
    wr(0, 3); wr(1, 4); wr(2, 6); wr(3, 2);
    do_arm();
    run_len(1'b1, n); check(n == 4, "R2 low-gate pulse", n, 4);
    run_len(1'b0, n); check(n == 3, "R2 low-gate delay", n, 3);
    gate = 1;
    repeat (30) @(negedge clk);
    run_len(1'b1, n); check(n == 2, "R3 high-gate pulse", n, 2);
    run_len(1'b0, n); check(n == 6, "R3 high-gate delay", n, 6);

    // R4: gate change mid-delay does not alter the phase in progress
    do_reset();
    gate = 0;
    wr(0, 10); wr(1, 3); wr(2, 2); wr(3, 2);
    do_arm();
    while (pulse_out != 1) @(negedge clk);
    while (pulse_out != 0) @(negedge clk);
    n = 0;
    while (pulse_out == 0 && n < 100) begin
      n++;
      if (n == 2) gate = 1;
      @(negedge clk);
    end
    check(n == 10, "R4 delay keeps original count", n, 10);
    n = 0;
    while (pulse_out == 1 && n < 100) begin n++; @(negedge clk); end
    check(n == 3, "R4 pulse keeps pair latched at delay start", n, 3);
    n = 0;
    while (pulse_out == 0 && n < 100) begin n++; @(negedge clk); end
    check(n == 2, "R4 new gate taken at next delay", n, 2);

    // R5: clamp of short counts; R6: tc rate
    do_reset();
    gate = 0;
    wr(0, 0); wr(1, 1);
    do_arm();
    run_len(1'b1, n); check(n == 2, "R5 count 1 clamped to 2", n, 2);
    run_len(1'b0, n); check(n == 2, "R5 count 0 clamped to 2", n, 2);
    n = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (tc) n++; end
    check(n == 10, "R6 one tc per period", n, 10);

    // R7: writes and arm ignored while running; reset stops
    do_reset();
    wr(0, 3); wr(1, 3);
    do_arm();
    wr(0, 9); wr(1, 8);
    do_arm();
    run_len(1'b1, n); check(n == 3, "R7 pulse write ignored while running", n, 3);
    run_len(1'b0, n); check(n == 3, "R7 delay write ignored while running", n, 3);
    do_reset();
    n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pulse_out) n++; end
    check(n == 0, "R7 reset stops generation", n, 0);

    // R8: polarity
    invert = 1;
    repeat (3) @(negedge clk);
    check(pulse_out == 1, "R8 idle output inverted", pulse_out, 1);
    wr(0, 3); wr(1, 4);
    do_arm();
    run_len(1'b0, n); check(n == 4, "R8 inverted active phase", n, 4);
    run_len(1'b1, n); check(n == 3, "R8 inverted delay phase", n, 3);
    invert = 0;

    // R9: sparse ticks stretch phases by the tick spacing
    do_reset();
    tick_div = 2;
    wr(0, 3); wr(1, 2);
    do_arm();
    run_len(1'b1, n); check(n == 4, "R9 pulse with tick every 2 clocks", n, 4);
    run_len(1'b0, n); check(n == 6, "R9 delay with tick every 2 clocks", n, 6);
    tick_div = 3;
    repeat (10) @(negedge clk);
    run_len(1'b1, n); check(n == 6, "R9 pulse with tick every 3 clocks", n, 6);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule